// File: doc/BRIEF.md
# Refresh Debt Scheduler

This block decides when a DDR SDRAM controller should issue auto-refresh commands. A free-running interval counter creates one refresh obligation each time the average refresh interval elapses. Obligations are not forced out at once: they pile up in an owed count. The controller may keep serving traffic and pay the debt later, up to a fixed cap. When the cap is reached the block raises an urgent flag, so that the controller closes its open rows and refreshes.

A refresh may only be issued once every bank has been precharged and the precharge period has passed. The controller reports this on a single "all banks idle" input. The block offers a refresh (`ref_req`) only when three things hold: debt is owed, the banks have been idle long enough, and the previous refresh-cycle window has closed. The controller accepts the offer by pulsing `ref_grant`. After each accepted refresh, `act_block` stays high until the refresh-cycle time has run out, and during that time no activate or further refresh may go out. The device generates the refresh row address itself, so the block has no address output.

Top module: `rfsh_debt_sched`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `ref_req`, `ref_urgent` and `act_block` are 0. The owed count and the interval counter restart from zero.
- R2: One obligation is added on every INTERVAL_CYC-th rising clock edge after reset is released (edges INTERVAL_CYC, 2*INTERVAL_CYC, and so on). So with the banks idle, `ref_req` first goes high right after edge INTERVAL_CYC.
- R3: `ref_req` is 1 exactly when the owed count is non-zero, the idle qualification of R8 holds and `act_block` is 0. Each accepted grant (`ref_grant` = 1 while `ref_req` = 1) lowers the owed count by one.
- R4: The owed count saturates at OWED_CAP. An interval tick that arrives while the count is already at OWED_CAP is lost.
- R5: `ref_urgent` is 1 exactly when the owed count equals OWED_CAP. It does not depend on the banks being idle.
- R6: A `ref_grant` given while `ref_req` is 0 is ignored. It changes neither the owed count nor `act_block`.
- R7: After the edge that accepts a grant, `act_block` is 1 for TRFC_CYC-1 cycles and then returns to 0. The earliest next command edge is therefore TRFC_CYC edges after the grant. `ref_req` is 0 while `act_block` is 1.
- R8: A refresh may only be offered when `banks_idle` is 1 in the current cycle and was also 1 at each of the preceding TRP_CYC-1 rising edges. A 0 on `banks_idle` restarts this qualification.
- R9: When an interval tick and an accepted grant fall on the same edge, the owed count is unchanged. This also holds at the cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | 1 when every bank of the device is precharged |
| ref_grant | input | 1 | Controller issues the offered refresh on this edge |
| ref_req | output | 1 | A refresh is owed and may legally be issued now |
| ref_urgent | output | 1 | Owed count has reached the cap; refresh must not be deferred further |
| act_block | output | 1 | Refresh-cycle window open; no activate or refresh may be issued |

## Verification
The hardest state to reach from the ports is a refresh debt sitting at the cap while a tick, a stray grant and a blocked window all interact. Reaching it needs several whole intervals with the banks kept busy, and the count itself is not visible. The stimulus holds `banks_idle` low across more intervals than the cap allows, so that an extra tick hits the saturated count. It then drains the debt one grant at a time and places one grant inside the blocked window. It reads the hidden count back from the number of grants needed before `ref_req` drops, and it lines up one grant with a tick edge to show that the two cancel.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Next owed count: add one on a tick, remove one on an accepted grant,
  // never above the cap. A tick at the cap with no grant is lost.
  function automatic int owed_step(input int owed, input bit tick,
                                   input bit take, input int cap);
    int nxt;
    nxt = owed;
    if (tick) nxt = nxt + 1;
    if (take) nxt = nxt - 1;
    if (nxt > cap) nxt = cap;
    if (nxt < 0) nxt = 0;
    return nxt;
  endfunction

  // Value loaded into a blocking window so that it reads non-zero for
  // len-1 cycles after the loading edge.
  function automatic int window_load(input int len);
    return (len > 1) ? len - 1 : 0;
  endfunction

  // Number of earlier idle edges that must have been seen before an
  // idle cycle counts as a full precharge period.
  function automatic int idle_history(input int trp);
    return (trp > 1) ? trp - 1 : 0;
  endfunction

  // Width that holds values 0..n.
  function automatic int width_for(input int n);
    return (n > 1) ? $clog2(n + 1) : 1;
  endfunction

endpackage

// File: rtl/rfsh_interval_ticker.sv
module rfsh_interval_ticker #(
  parameter int INTERVAL_CYC = 1040
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import rfsh_pkg::*;

  localparam int CW = width_for(INTERVAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (INTERVAL_CYC > 1) begin : g_spacing
      // R2: ticks are never back to back
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/rfsh_owed_tracker.sv
module rfsh_owed_tracker #(
  parameter int OWED_CAP = 8,
  parameter int OW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  output logic [OW-1:0] owed,
  output logic          owed_nz,
  output logic          owed_full
);
  import rfsh_pkg::*;

  localparam logic [OW-1:0] CAP_V = OW'(OWED_CAP);

  logic [OW-1:0] owed_q;
  logic [OW-1:0] owed_d;

  always_comb begin
    owed_d = OW'(owed_step(int'(owed_q), tick, take, OWED_CAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_d;
  end

  assign owed      = owed_q;
  assign owed_nz   = (owed_q != '0);
  assign owed_full = (owed_q == CAP_V);

  // R4: the debt never exceeds the cap
  assert_owed_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= CAP_V);

  // R5: the urgent condition persists until a refresh is taken
  assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_full && !take) |=> owed_full);

  // R3: an accepted grant without a tick pays one obligation
  assert_take_pays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tick) |=> (owed_q == $past(owed_q) - 1'b1));

  // R9: tick and grant on one edge cancel
  assert_tick_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tick) |=> $stable(owed_q));

endmodule

// File: rtl/rfsh_window_timer.sv
module rfsh_window_timer #(
  parameter int LEN_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  import rfsh_pkg::*;

  localparam int TW = width_for(LEN_CYC);
  localparam logic [TW-1:0] LOADV = TW'(window_load(LEN_CYC));

  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (start)           left_q <= LOADV;
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

  generate
    if (LEN_CYC > 1) begin : g_win
      // R7: a started window is visible on the next cycle
      assert_window_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
      // R7: the window only shrinks unless restarted
      assert_window_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (left_q == $past(left_q) - 1'b1));
    end
  endgenerate

endmodule

// File: rtl/rfsh_idle_qual.sv
module rfsh_idle_qual #(
  parameter int TRP_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  output logic ok
);
  import rfsh_pkg::*;

  localparam int NEED = idle_history(TRP_CYC);
  localparam int QW   = width_for(NEED);
  localparam logic [QW-1:0] NEED_V = QW'(NEED);

  logic [QW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              seen_q <= '0;
    else if (!idle)          seen_q <= '0;
    else if (seen_q < NEED_V) seen_q <= seen_q + 1'b1;
  end

  assign ok = idle && (seen_q >= NEED_V);

  generate
    if (TRP_CYC > 1) begin : g_q
      // R8: a busy cycle disqualifies the following cycle
      assert_idle_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> !ok);
    end
  endgenerate

endmodule

// File: rtl/rfsh_debt_sched.sv
module rfsh_debt_sched #(
  parameter int INTERVAL_CYC = 1040,
  parameter int OWED_CAP     = 8,
  parameter int TRFC_CYC     = 10,
  parameter int TRP_CYC      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic ref_grant,
  output logic ref_req,
  output logic ref_urgent,
  output logic act_block
);
  import rfsh_pkg::*;

  localparam int OW = width_for(OWED_CAP);

  // named internal events
  logic          tick;
  logic          take;
  logic          owed_nz;
  logic          owed_full;
  logic          rfc_busy;
  logic          idle_ok;
  logic [OW-1:0] owed;

  rfsh_interval_ticker #(.INTERVAL_CYC(INTERVAL_CYC)) u_ticker (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  rfsh_owed_tracker #(.OWED_CAP(OWED_CAP), .OW(OW)) u_owed (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .take     (take),
    .owed     (owed),
    .owed_nz  (owed_nz),
    .owed_full(owed_full)
  );

  rfsh_window_timer #(.LEN_CYC(TRFC_CYC)) u_rfc (
    .clk  (clk),
    .rst_n(rst_n),
    .start(take),
    .busy (rfc_busy)
  );

  rfsh_idle_qual #(.TRP_CYC(TRP_CYC)) u_idle (
    .clk  (clk),
    .rst_n(rst_n),
    .idle (banks_idle),
    .ok   (idle_ok)
  );

  assign ref_req    = owed_nz && idle_ok && !rfc_busy;
  assign ref_urgent = owed_full;
  assign act_block  = rfc_busy;
  assign take       = ref_grant && ref_req;

  // R8: never offer a refresh with a bank open
  assert_req_needs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> banks_idle);

  // R7: no offer inside the refresh-cycle window
  assert_block_masks_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_block |-> !ref_req);

  // R7: the window only opens because a refresh was taken
  assert_block_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_block) |-> $past(take));

  // R6: a stray grant leaves the debt alone
  assert_stray_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant && !ref_req && !tick) |=> $stable(owed));

  // R5: urgency only appears on an interval tick
  assert_urgent_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_urgent) |-> $past(tick));

endmodule

// File: tb/test_rfsh_debt_sched.sv
module test_rfsh_debt_sched;

  localparam int IV   = 32;
  localparam int CAP  = 4;
  localparam int TRFC = 10;
  localparam int TRP  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic banks_idle;
  logic ref_grant;
  logic ref_req;
  logic ref_urgent;
  logic act_block;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rfsh_debt_sched #(
    .INTERVAL_CYC(IV), .OWED_CAP(CAP), .TRFC_CYC(TRFC), .TRP_CYC(TRP)
  ) i_rfsh_debt_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .banks_idle(banks_idle),
    .ref_grant (ref_grant),
    .ref_req   (ref_req),
    .ref_urgent(ref_urgent),
    .act_block (act_block)
  );

  // Row: {req tag, idle, grant pulse, cycles, exp req, exp urgent, exp block}
  // Edge count t since release is given for each row end.
  localparam int NROW = 29;
  localparam logic [16:0] TBL [NROW] = '{
    {4'd2, 1'b1, 1'b0, 8'd31, 3'b000},  // R2 t=31 nothing owed yet
    {4'd2, 1'b1, 1'b0, 8'd1,  3'b100},  // R2 t=32 first obligation
    {4'd7, 1'b1, 1'b1, 8'd1,  3'b001},  // R7 t=33 window opens
    {4'd7, 1'b1, 1'b0, 8'd8,  3'b001},  // R7 t=41 last blocked cycle
    {4'd7, 1'b1, 1'b0, 8'd1,  3'b000},  // R7 t=42 window closed
    {4'd8, 1'b0, 1'b0, 8'd22, 3'b000},  // R8 t=64 owed 1, banks busy
    {4'd5, 1'b0, 1'b0, 8'd96, 3'b010},  // R5 t=160 owed at cap
    {4'd4, 1'b0, 1'b0, 8'd32, 3'b010},  // R4 t=192 tick lost at cap
    {4'd8, 1'b1, 1'b0, 8'd1,  3'b010},  // R8 t=193 idle too short
    {4'd3, 1'b1, 1'b0, 8'd1,  3'b110},  // R3 t=194 offer while urgent
    {4'd5, 1'b1, 1'b1, 8'd1,  3'b001},  // R5 t=195 owed 3, urgency drops
    {4'd6, 1'b1, 1'b1, 8'd1,  3'b001},  // R6 t=196 stray grant in window
    {4'd7, 1'b1, 1'b0, 8'd8,  3'b100},  // R7 t=204 offer again
    {4'd3, 1'b1, 1'b1, 8'd1,  3'b001},  // R3 t=205 owed 2
    {4'd3, 1'b1, 1'b0, 8'd9,  3'b100},  // R3 t=214
    {4'd3, 1'b1, 1'b1, 8'd10, 3'b100},  // R3 t=224 owed 1 then tick -> 2
    {4'd3, 1'b1, 1'b1, 8'd10, 3'b100},  // R3 t=234 owed 1
    {4'd6, 1'b1, 1'b1, 8'd10, 3'b000},  // R6 t=244 owed 0: stray grant was not counted
    {4'd2, 1'b1, 1'b0, 8'd43, 3'b100},  // R2 t=287 owed 1 from t=256
    {4'd9, 1'b1, 1'b1, 8'd1,  3'b001},  // R9 t=288 grant on tick edge
    {4'd9, 1'b1, 1'b0, 8'd9,  3'b100},  // R9 t=297 still owed 1
    {4'd3, 1'b1, 1'b1, 8'd1,  3'b001},  // R3 t=298 owed 0
    {4'd3, 1'b1, 1'b0, 8'd9,  3'b000},  // R3 t=307 nothing owed
    {4'd8, 1'b0, 1'b0, 8'd14, 3'b000},  // R8 t=321 owed 1, busy
    {4'd8, 1'b1, 1'b0, 8'd1,  3'b000},  // R8 t=322 one idle edge
    {4'd8, 1'b0, 1'b0, 8'd1,  3'b000},  // R8 t=323 busy again
    {4'd8, 1'b1, 1'b0, 8'd1,  3'b000},  // R8 t=324 restarted count
    {4'd8, 1'b1, 1'b0, 8'd1,  3'b100},  // R8 t=325 qualified
    {4'd3, 1'b1, 1'b1, 8'd10, 3'b000}   // R3 t=335 debt paid
  };

  task automatic chk(input string what, input int tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk3(input int tag, input logic [2:0] exp);
    chk("ref_req",    tag, ref_req,    exp[2]);
    chk("ref_urgent", tag, ref_urgent, exp[1]);
    chk("act_block",  tag, act_block,  exp[0]);
  endtask

  task automatic run(input logic idle, input logic gnt, input int n);
    banks_idle = idle;
    ref_grant  = gnt;
    @(negedge clk);
    ref_grant = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    rst_n      = 1'b0;
    banks_idle = 1'b1;
    ref_grant  = 1'b0;
    repeat (3) @(negedge clk);
    chk3(1, 3'b000);  // R1 outputs low in reset
    rst_n = 1'b1;     // t=0 from here
    chk3(1, 3'b000);  // R1 first cycle after release

    for (int i = 0; i < NROW; i++) begin
      run(TBL[i][12], TBL[i][11], int'(TBL[i][10:3]));
      chk3(int'(TBL[i][16:13]), TBL[i][2:0]);
    end

    // directed: reset inside an open window (t=335 here)
    run(1'b1, 1'b0, 17);   // t=352, owed 1
    chk3(2, 3'b100);       // R2
    run(1'b1, 1'b1, 1);    // t=353
    chk3(7, 3'b001);       // R7
    rst_n = 1'b0;
    @(negedge clk);
    chk3(1, 3'b000);       // R1 window cleared by reset
    rst_n = 1'b1;          // restart counting
    run(1'b1, 1'b0, IV - 1);
    chk3(1, 3'b000);       // R1 interval counter restarted
    run(1'b1, 1'b0, 1);
    chk3(2, 3'b100);       // R2 first tick after new release

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule